// File: doc/BRIEF.md
# Multi-site thermal monitor controller

This block is the register-mapped control side of an on-die temperature monitor with up to sixteen sensing sites. A host reaches it through a 32-bit request/response bus. Each site presents a 10-bit raw reading on its own input lane. When the host sets the monitor-enable bit, a scan sequencer walks the site positions and copies the reading of every enabled site into that site's result word. The result word carries a ready flag. Between scans the sequencer waits for a programmable number of cycles.

The block also holds a read-only revision word and a small set of plain storage words. The revision word lets software pick the register layout. The storage words are an interrupt-enable word, temperature-range control words, and a calibration table that is loaded through a select word and a data word. The layout generation is chosen by the `VERSION` parameter (1 or 2). The two layouts differ in where the site-enable bits live, in where the interval word sits, in how many range words exist, and in the width of the temperature field.

Top module: `tmon_top`

## Requirements
- R1: After reset, the mode word (0x000) reads 0, the interval word reads 0x0000000F, and every result word has bit 31 clear.
- R2: Offset 0xBF8 is read-only and returns `VERSION` in bits 15:8, with all other bits 0 (0x00000200 for layout 2, 0x00000100 for layout 1).
- R3: `req_ready` is always high. Every cycle with `req_valid` high is followed in the next cycle by `rsp_valid` high. A cycle without a request is followed by `rsp_valid` low. For a read, `rsp_rdata` carries the addressed word.
- R4: In layout 2, bit n of the site word at 0x008 enables site n, and the interval word sits at 0x00C. Only bits 31, 25 and 24 of the mode word are writable.
- R5: In layout 1, site n is enabled by bit (15 − n) of the mode word, and the interval word sits at 0x008. Offset 0x00C is unmapped. Bits 31, 27:26 and 15:0 of the mode word are writable.
- R6: The result word of site n is at 0x100 + 16·n. Bit 31 is the ready flag.
  - In layout 2, bits 9:0 hold the raw reading: kelvin in bits 8:0 and the half-degree flag in bit 9.
  - In layout 1, bits 7:0 hold the low 8 raw bits (degrees Celsius).
  - All other bits read 0.
- R7: Bus writes to result words change nothing.
- R8: Bit 31 of the mode word is the monitor enable. Once it is set, the sequencer steps one site position per cycle in ascending order, starting at position 0, and captures each enabled site. Every enabled site is ready within `NSITES`+2 cycles. Disabled sites stay not-ready.
- R9: A result word reads not-ready until its first capture after enable. Clearing the enable bit clears every ready flag in the next cycle and keeps the last temperature fields.
- R10: After a full sweep, the sequencer idles for (interval + 1) cycles and then sweeps again. While it idles, input changes do not reach the result words.
- R11: A write to 0x080 selects a calibration entry. A write to 0x084 stores its data into the selected entry. A read of 0x084 returns the selected entry, and a read of 0x080 returns the selection.
- R12: Range words sit at 0xF10 + 4·n: 16 of them in layout 2 and 4 in layout 1. They can be read and written. Offsets past the last range word read 0 and ignore writes.
- R13: The interrupt-enable word at 0x020 stores all 32 bits. Any unmapped offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always high) |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| site_temp | input | NSITES*10 | Raw reading of site n in bits 10n+9:10n |

## Verification
The scan is driven with a sparse site mask (sites 2, 5 and 15) and a mix of raw values, one with the half-degree bit set. This tells captured sites apart from skipped ones and the 10-bit field from a truncated one. A second instance in layout 1 is enabled with the single mode bit 11. The check that site 4 becomes ready and site 11 does not separates the reversed mask from a straight one. The same input change is applied once under a long interval and once under a zero interval. A hold in the first case and a refresh in the second separate the idle window from a free-running capture. The calibration entries are written interleaved and read back, so that a design that ignores the selection is caught.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam logic [11:0] OFS_MODE     = 12'h000;
  localparam logic [11:0] OFS_V1_INTV  = 12'h008;
  localparam logic [11:0] OFS_V2_SITES = 12'h008;
  localparam logic [11:0] OFS_V2_INTV  = 12'h00C;
  localparam logic [11:0] OFS_IEN      = 12'h020;
  localparam logic [11:0] OFS_CAL_SEL  = 12'h080;
  localparam logic [11:0] OFS_CAL_DATA = 12'h084;
  localparam logic [11:0] OFS_RES_BASE = 12'h100;
  localparam logic [11:0] OFS_RNG_BASE = 12'hF10;
  localparam logic [11:0] OFS_REV      = 12'hBF8;

  typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_WAIT} scan_st_e;

  function automatic logic [31:0] mode_wmask(input int unsigned ver);
    return (ver == 1) ? 32'h8C00_FFFF : 32'h8300_0000;
  endfunction

  function automatic int unsigned range_count(input int unsigned ver);
    return (ver == 1) ? 4 : 16;
  endfunction
endpackage

// File: rtl/tmon_scan.sv
module tmon_scan
  import tmon_pkg::*;
#(
  parameter int unsigned VERSION = 2,
  parameter int unsigned NSITES  = 16,
  parameter int unsigned TEMP_W  = 10,
  parameter int unsigned INTV_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mon_en_i,
  input  logic [NSITES-1:0]            site_mask_i,
  input  logic [INTV_W-1:0]            interval_i,
  input  logic [NSITES*TEMP_W-1:0]     site_temp_i,
  output logic [NSITES-1:0][31:0]      res_words_o
);
  localparam int unsigned SIW = $clog2(NSITES);
  localparam logic [SIW-1:0] LAST = SIW'(NSITES - 1);

  scan_st_e st_q, st_d;
  logic [SIW-1:0] ptr_q, ptr_d;
  logic [INTV_W-1:0] cnt_q, cnt_d;
  logic cap;
  logic [NSITES-1:0] vld_q, vld_d, upd;
  logic [NSITES-1:0][TEMP_W-1:0] temp_q;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    cap   = 1'b0;
    if (!mon_en_i) begin
      st_d  = SC_IDLE;
      ptr_d = '0;
      cnt_d = '0;
    end else begin
      case (st_q)
        SC_IDLE: begin
          st_d  = SC_SCAN;
          ptr_d = '0;
        end
        SC_SCAN: begin
          cap = 1'b1;
          if (ptr_q == LAST) begin
            st_d  = SC_WAIT;
            cnt_d = interval_i;
          end else begin
            ptr_d = ptr_q + SIW'(1);
          end
        end
        SC_WAIT: begin
          if (cnt_q == '0) begin
            st_d  = SC_SCAN;
            ptr_d = '0;
          end else begin
            cnt_d = cnt_q - INTV_W'(1);
          end
        end
        default: st_d = SC_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int n = 0; n < NSITES; n++) begin
      upd[n]   = cap && (ptr_q == SIW'(n)) && site_mask_i[n];
      vld_d[n] = mon_en_i && (upd[n] || vld_q[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SC_IDLE;
      ptr_q <= '0;
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
    end else begin
      for (int n = 0; n < NSITES; n++)
        if (upd[n]) temp_q[n] <= site_temp_i[n*TEMP_W +: TEMP_W];
    end
  end

  generate
    for (genvar n = 0; n < NSITES; n++) begin : g_site
      if (VERSION == 1) begin : g_fmt1
        assign res_words_o[n] = {vld_q[n], 23'b0, temp_q[n][7:0]};
      end else begin : g_fmt2
        assign res_words_o[n] = {vld_q[n], {(31-TEMP_W){1'b0}}, temp_q[n]};
      end

      // R8
      vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld_q[n]) |-> $past(mon_en_i && site_mask_i[n] && st_q == SC_SCAN && ptr_q == SIW'(n)));
    end
  endgenerate

  // R9
  dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en_i |=> (vld_q == '0));

  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_WAIT) |=> $stable(temp_q));

  // R8
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_SCAN && mon_en_i && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + SIW'(1)));
endmodule

// File: rtl/tmon_regs.sv
module tmon_regs
  import tmon_pkg::*;
#(
  parameter int unsigned VERSION   = 2,
  parameter int unsigned NSITES    = 16,
  parameter int unsigned INTV_W    = 16,
  parameter int unsigned CAL_DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [11:0]             req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    req_ready,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  input  logic [NSITES-1:0][31:0] res_words_i,
  output logic                    mon_en_o,
  output logic [NSITES-1:0]       site_mask_o,
  output logic [INTV_W-1:0]       interval_o
);
  localparam int unsigned NRANGE = range_count(VERSION);
  localparam int unsigned RNG_IW = $clog2(NRANGE);
  localparam int unsigned CAL_IW = $clog2(CAL_DEPTH);
  localparam int unsigned SIW    = $clog2(NSITES);
  localparam logic [31:0] MODE_WM = mode_wmask(VERSION);
  localparam logic [11:0] INTV_OFS = (VERSION == 1) ? OFS_V1_INTV : OFS_V2_INTV;

  logic fire, wr_fire;
  logic hit_mode, hit_intv, hit_sites, hit_ien, hit_csel, hit_cdata, hit_rev, hit_res, hit_rng;
  logic [11:0] rng_off;
  logic [9:0]  rng_idx;
  logic [7:0]  res_idx;

  logic [31:0] mode_q, mode_d, ien_q, ien_d, rd_d;
  logic [INTV_W-1:0] intv_q, intv_d;
  logic [NSITES-1:0] sites_q, sites_d;
  logic [CAL_IW-1:0] csel_q, csel_d;
  logic [CAL_DEPTH-1:0][31:0] cal_q;
  logic [NRANGE-1:0][31:0] rng_q;
  logic [CAL_DEPTH-1:0] cal_we;
  logic [NRANGE-1:0] rng_we;

  assign req_ready = 1'b1;
  assign fire      = req_valid;
  assign wr_fire   = fire && req_write;

  always_comb begin
    rng_off   = req_addr - OFS_RNG_BASE;
    rng_idx   = rng_off[11:2];
    res_idx   = req_addr[11:4] - OFS_RES_BASE[11:4];
    hit_mode  = (req_addr == OFS_MODE);
    hit_intv  = (req_addr == INTV_OFS);
    hit_sites = (VERSION != 1) && (req_addr == OFS_V2_SITES);
    hit_ien   = (req_addr == OFS_IEN);
    hit_csel  = (req_addr == OFS_CAL_SEL);
    hit_cdata = (req_addr == OFS_CAL_DATA);
    hit_rev   = (req_addr == OFS_REV);
    hit_res   = (req_addr >= OFS_RES_BASE) && (req_addr[3:0] == 4'h0) && ({24'b0, res_idx} < NSITES);
    hit_rng   = (req_addr >= OFS_RNG_BASE) && (rng_off[1:0] == 2'b00) && ({22'b0, rng_idx} < NRANGE);
  end

  always_comb begin
    mode_d  = (wr_fire && hit_mode)  ? (req_wdata & MODE_WM) : mode_q;
    intv_d  = (wr_fire && hit_intv)  ? req_wdata[INTV_W-1:0] : intv_q;
    sites_d = (wr_fire && hit_sites) ? req_wdata[NSITES-1:0] : sites_q;
    ien_d   = (wr_fire && hit_ien)   ? req_wdata : ien_q;
    csel_d  = (wr_fire && hit_csel)  ? req_wdata[CAL_IW-1:0] : csel_q;
    cal_we  = '0;
    rng_we  = '0;
    if (wr_fire && hit_cdata) cal_we[csel_q] = 1'b1;
    if (wr_fire && hit_rng)   rng_we[rng_idx[RNG_IW-1:0]] = 1'b1;
  end

  always_comb begin
    rd_d = '0;
    if (!req_write) begin
      if (hit_mode)  rd_d = mode_q;
      if (hit_intv)  rd_d = 32'(intv_q);
      if (hit_sites) rd_d = 32'(sites_q);
      if (hit_ien)   rd_d = ien_q;
      if (hit_csel)  rd_d = 32'(csel_q);
      if (hit_cdata) rd_d = cal_q[csel_q];
      if (hit_rev)   rd_d = {16'h0, 8'(VERSION), 8'h00};
      if (hit_res)   rd_d = res_words_i[res_idx[SIW-1:0]];
      if (hit_rng)   rd_d = rng_q[rng_idx[RNG_IW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      intv_q    <= INTV_W'(15);
      sites_q   <= '0;
      ien_q     <= '0;
      csel_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      mode_q    <= mode_d;
      intv_q    <= intv_d;
      sites_q   <= sites_d;
      ien_q     <= ien_d;
      csel_q    <= csel_d;
      rsp_valid <= fire;
      if (fire) rsp_rdata <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q <= '0;
      rng_q <= '0;
    end else begin
      for (int i = 0; i < CAL_DEPTH; i++) if (cal_we[i]) cal_q[i] <= req_wdata;
      for (int i = 0; i < NRANGE; i++)    if (rng_we[i]) rng_q[i] <= req_wdata;
    end
  end

  assign mon_en_o   = mode_q[31];
  assign interval_o = intv_q;

  generate
    if (VERSION == 1) begin : g_mask_v1
      for (genvar n = 0; n < NSITES; n++) begin : g_rev
        assign site_mask_o[n] = mode_q[15-n];
      end
    end else begin : g_mask_v2
      assign site_mask_o = sites_q;
    end
  endgenerate

  // R3
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R3
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R11
  cal_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && hit_cdata) |=> (cal_q[$past(csel_q)] == $past(req_wdata)));
endmodule

// File: rtl/tmon_top.sv
module tmon_top #(
  parameter int unsigned VERSION   = 2,
  parameter int unsigned NSITES    = 16,
  parameter int unsigned TEMP_W    = 10,
  parameter int unsigned INTV_W    = 16,
  parameter int unsigned CAL_DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [11:0]              req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     req_ready,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  input  logic [NSITES*TEMP_W-1:0] site_temp
);
  logic                    mon_en;
  logic [NSITES-1:0]       site_mask;
  logic [INTV_W-1:0]       interval;
  logic [NSITES-1:0][31:0] res_words;

  tmon_regs #(
    .VERSION(VERSION), .NSITES(NSITES), .INTV_W(INTV_W), .CAL_DEPTH(CAL_DEPTH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .res_words_i(res_words), .mon_en_o(mon_en), .site_mask_o(site_mask), .interval_o(interval)
  );

  tmon_scan #(
    .VERSION(VERSION), .NSITES(NSITES), .TEMP_W(TEMP_W), .INTV_W(INTV_W)
  ) u_scan (
    .clk(clk), .rst_n(rst_n),
    .mon_en_i(mon_en), .site_mask_i(site_mask), .interval_i(interval),
    .site_temp_i(site_temp), .res_words_o(res_words)
  );
endmodule

// File: tb/tmon_top_tb.sv
`timescale 1ns/1ps
module tmon_top_tb;
  typedef struct packed {
    logic        sel;   // 0 = layout 2, 1 = layout 1
    logic        we;
    logic        chk;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b0, 4'd13, 12'h020, 32'h0000_0005, 32'h0},           // R13
    '{1'b0, 1'b0, 1'b1, 4'd13, 12'h020, 32'h0, 32'h0000_0005},
    '{1'b0, 1'b0, 1'b1, 4'd2,  12'hBF8, 32'h0, 32'h0000_0200},           // R2
    '{1'b1, 1'b0, 1'b1, 4'd2,  12'hBF8, 32'h0, 32'h0000_0100},
    '{1'b0, 1'b0, 1'b1, 4'd4,  12'h00C, 32'h0, 32'h0000_000F},           // R4
    '{1'b1, 1'b0, 1'b1, 4'd5,  12'h008, 32'h0, 32'h0000_000F},           // R5
    '{1'b1, 1'b0, 1'b1, 4'd5,  12'h00C, 32'h0, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'd4,  12'h000, 32'h0000_FFFF, 32'h0},
    '{1'b0, 1'b0, 1'b1, 4'd4,  12'h000, 32'h0, 32'h0},
    '{1'b1, 1'b1, 1'b0, 4'd5,  12'h000, 32'h0000_00A5, 32'h0},
    '{1'b1, 1'b0, 1'b1, 4'd5,  12'h000, 32'h0, 32'h0000_00A5},
    '{1'b0, 1'b1, 1'b0, 4'd12, 12'hF4C, 32'h0000_A5A5, 32'h0},           // R12
    '{1'b0, 1'b0, 1'b1, 4'd12, 12'hF4C, 32'h0, 32'h0000_A5A5},
    '{1'b1, 1'b1, 1'b0, 4'd12, 12'hF1C, 32'h0000_0007, 32'h0},
    '{1'b1, 1'b0, 1'b1, 4'd12, 12'hF1C, 32'h0, 32'h0000_0007},
    '{1'b1, 1'b1, 1'b0, 4'd12, 12'hF20, 32'h0000_0009, 32'h0},
    '{1'b1, 1'b0, 1'b1, 4'd12, 12'hF20, 32'h0, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'd11, 12'h080, 32'h0000_0003, 32'h0},           // R11
    '{1'b0, 1'b1, 1'b0, 4'd11, 12'h084, 32'h0000_1234, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'd11, 12'h080, 32'h0000_0004, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'd11, 12'h084, 32'h0000_0055, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'd11, 12'h080, 32'h0000_0003, 32'h0},
    '{1'b0, 1'b0, 1'b1, 4'd11, 12'h084, 32'h0, 32'h0000_1234},
    '{1'b0, 1'b0, 1'b1, 4'd11, 12'h080, 32'h0, 32'h0000_0003},
    '{1'b0, 1'b1, 1'b0, 4'd13, 12'h300, 32'h0000_0001, 32'h0},
    '{1'b0, 1'b0, 1'b1, 4'd13, 12'h300, 32'h0, 32'h0}
  };

  logic clk, rst_n;
  logic vld2, vld1, wr;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic rdy2, rdy1, rsp2, rsp1;
  logic [31:0] rdata2, rdata1;
  logic [159:0] temps;
  int nchk, nfail;
  logic done;
  logic [31:0] r;
  logic rsp_seen;

  tmon_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(vld2), .req_write(wr), .req_addr(addr),
    .req_wdata(wdata), .req_ready(rdy2), .rsp_valid(rsp2), .rsp_rdata(rdata2), .site_temp(temps)
  );

  tmon_top #(.VERSION(1)) u_dut_v1 (
    .clk(clk), .rst_n(rst_n), .req_valid(vld1), .req_write(wr), .req_addr(addr),
    .req_wdata(wdata), .req_ready(rdy1), .rsp_valid(rsp1), .rsp_rdata(rdata1), .site_temp(temps)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic sel, input logic we, input logic [11:0] a,
                     input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    addr = a; wdata = d; wr = we; vld2 = !sel; vld1 = sel;
    @(negedge clk);
    rd = sel ? rdata1 : rdata2;
    rsp_seen = sel ? rsp1 : rsp2;
    vld1 = 1'b0; vld2 = 1'b0;
  endtask

  task automatic set_temp(input int n, input logic [9:0] v);
    temps[n*10 +: 10] = v;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    nchk = 0; nfail = 0; done = 1'b0;
    rst_n = 1'b0; vld1 = 1'b0; vld2 = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    for (int n = 0; n < 16; n++) temps[n*10 +: 10] = 10'(n * 13 + 40);
    set_temp(5, 10'h3A5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus(1'b0, 1'b0, 12'h000, 32'h0, r); chk("R1 mode", r, 32'h0);
    bus(1'b0, 1'b0, 12'h120, 32'h0, r); chk("R1 result", r, 32'h0);
    bus(1'b1, 1'b0, 12'h1F0, 32'h0, r); chk("R1 result v1", r, 32'h0);

    // R3 response timing
    bus(1'b0, 1'b0, 12'hBF8, 32'h0, r); chk("R3 rsp_valid", {31'b0, rsp_seen}, 32'h1);
    chk("R3 req_ready", {31'b0, rdy2}, 32'h1);
    @(negedge clk); chk("R3 idle", {31'b0, rsp2}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].sel, VEC[i].we, VEC[i].addr, VEC[i].data, r);
      if (VEC[i].chk) chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
    end

    // R8 / R9: sites 2, 5, 15 with a long idle window
    bus(1'b0, 1'b1, 12'h008, 32'h0000_8024, r);
    bus(1'b0, 1'b1, 12'h00C, 32'h0000_FFFF, r);
    bus(1'b0, 1'b1, 12'h000, 32'h8000_0000, r);
    bus(1'b0, 1'b0, 12'h1F0, 32'h0, r); chk("R9 not ready before capture", r, 32'h0);
    repeat (25) @(negedge clk);
    // R6 result format
    bus(1'b0, 1'b0, 12'h120, 32'h0, r); chk("R6 site2", r, 32'h8000_0000 | 32'(10'(2*13+40)));
    bus(1'b0, 1'b0, 12'h150, 32'h0, r); chk("R6 site5 half-degree", r, 32'h8000_03A5);
    bus(1'b0, 1'b0, 12'h1F0, 32'h0, r); chk("R8 site15", r, 32'h8000_0000 | 32'(10'(15*13+40)));
    bus(1'b0, 1'b0, 12'h130, 32'h0, r); chk("R8 site3 disabled", r, 32'h0);

    // R7 result word is read-only
    bus(1'b0, 1'b1, 12'h120, 32'h0000_0000, r);
    bus(1'b0, 1'b0, 12'h120, 32'h0, r); chk("R7 write ignored", r, 32'h8000_0000 | 32'd66);

    // R10 hold during idle window
    set_temp(2, 10'h111);
    repeat (30) @(negedge clk);
    bus(1'b0, 1'b0, 12'h120, 32'h0, r); chk("R10 hold", r, 32'h8000_0000 | 32'd66);

    // R9 disable clears ready, keeps temperature
    bus(1'b0, 1'b1, 12'h000, 32'h0, r);
    bus(1'b0, 1'b0, 12'h120, 32'h0, r); chk("R9 disable clears", r, 32'd66);

    // R10 zero interval refreshes
    bus(1'b0, 1'b1, 12'h00C, 32'h0, r);
    bus(1'b0, 1'b1, 12'h000, 32'h8000_0000, r);
    repeat (25) @(negedge clk);
    bus(1'b0, 1'b0, 12'h120, 32'h0, r); chk("R10 recapture", r, 32'h8000_0111);
    set_temp(2, 10'h0AB);
    repeat (40) @(negedge clk);
    bus(1'b0, 1'b0, 12'h120, 32'h0, r); chk("R10 periodic", r, 32'h8000_00AB);

    // R5 reversed mask in layout 1: mode bit 11 enables site 4
    bus(1'b1, 1'b1, 12'h000, 32'h8000_0800, r);
    repeat (25) @(negedge clk);
    bus(1'b1, 1'b0, 12'h140, 32'h0, r); chk("R5 site4 enabled", r, 32'h8000_0000 | 32'(8'(4*13+40)));
    bus(1'b1, 1'b0, 12'h1B0, 32'h0, r); chk("R5 site11 disabled", r, 32'h0);
    bus(1'b1, 1'b0, 12'h150, 32'h0, r); chk("R6 v1 field", r, 32'h0);

    finish_run();
  end
endmodule